// File: doc/BRIEF.md
# Upset Event Classifier and Repair Dispatcher

This block sits between a queue of configuration-memory error events and the engine that rewrites configuration memory from a trusted copy. The queue presents its head entry on its read port and says whether it holds anything. The block pops one event at a time and splits it into fields: frame address, word index of the syndrome, bit index, and three flags. The flags are the frame-ECC flag, the CRC flag and the odd-count flag. A fixed decision tree sorts the event into one upset class. Each class maps to one of three outcomes: rewrite one frame at the event's address, rewrite the whole configuration memory, or do nothing.

A single upset usually shows up as several events that carry the same frame address. The block remembers the address of the last upset it sent for repair. Events that repeat that address are discarded as duplicates, until an event with a different address arrives. After a full-memory rewrite has been acknowledged, every event still waiting in the queue is stale, so the block pops and discards all of them. The block reports each classified event on a one-cycle class strobe and keeps one event counter per class.

The event record is 64 bits wide. From bit 0 upward it holds the frame address (FADDR_W bits), the word index (WIDX_W bits) and the bit index (BIDX_W bits). Above these sit the frame-ECC flag, the CRC flag and the odd-count flag. The remaining upper bits are padding and are ignored. With the default parameters (26, 7, 5) the three flags are at bits 38, 39 and 40.

Top module: `upset_dispatch`

## Requirements
- R1: An event whose frame address field is zero is classified as class 0 (none) and no repair request is issued.
- R2: An event with the frame-ECC flag clear and the CRC flag set is classified as class 1 (unknown) and issues a full-memory request (rep_full_o = 1).
- R3: An event with the frame-ECC flag set and the odd-count flag clear is classified as class 2 (even multi-bit) and issues a frame request at the event's frame address (rep_full_o = 0).
- R4: An event with the frame-ECC flag set, the odd-count flag set and a word index of FRAME_WORDS or more is classified as class 3 (odd, out of bounds) and issues a full-memory request.
- R5: An event with the frame-ECC flag set, the odd-count flag set and a word index below FRAME_WORDS is handled by its CRC flag. With the CRC flag set it is class 4 (odd, in bounds) and issues a frame request at the event's address. With the CRC flag clear it is class 5 (single bit, already corrected) and issues no request.
- R6: An event with a nonzero address and both the frame-ECC flag and the CRC flag clear is class 0 (none) and issues no request. The padding bits never affect the result.
- R7: The block remembers the address of the last event that issued a request. An event with a nonzero address equal to the remembered one is class 6 (duplicate) and issues no request. The first later event with a different nonzero address clears the memory, so the earlier address is classified normally again afterwards.
- R8: Once a full-memory request has been acknowledged, all events still in the queue are popped without being classified or counted.
- R9: q_pop_o is never high while rep_req_o is high. rep_req_o, rep_full_o and rep_addr_o hold steady from the rise of rep_req_o until the first cycle in which rep_ack_i is high.
- R10: cnt_o holds one CNT_W-bit counter per class, class k at bits [k*CNT_W +: CNT_W]. A counter goes up by one for each event classified into its class.
- R11: After reset q_pop_o, rep_req_o and cls_valid_o are low and every counter is zero.
- R12: An event that is popped at clock edge n raises cls_valid_o for exactly the cycle after edge n+1. When the event calls for repair, rep_req_o rises at that same edge n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_nempty_i | input | 1 | Event queue holds at least one entry |
| q_pop_o | output | 1 | Pop the head entry at this clock edge |
| q_data_i | input | EV_W | Head entry of the event queue |
| rep_req_o | output | 1 | Repair request, held until acknowledged |
| rep_full_o | output | 1 | 1 = rewrite whole memory, 0 = rewrite one frame |
| rep_addr_o | output | FADDR_W | Frame address for the repair |
| rep_ack_i | input | 1 | Repair engine accepts the request |
| cls_valid_o | output | 1 | One-cycle strobe for a classified event |
| cls_o | output | 3 | Class code of the last classified event |
| cnt_o | output | 7*CNT_W | Per-class event counters |

## Verification
The bench builds the block with a 4-bit frame address, a 3-bit word index, a 2-bit bit index and FRAME_WORDS = 5. With these values, word indices 5 to 7 fall outside the frame, so every branch of the decision tree is reachable within a small space. The bench then sweeps all 16 addresses against all 64 combinations of word index and flags. The address rotates from one event to the next, so zero addresses, duplicate hits and duplicate-clearing events all occur naturally. Directed sequences cover repeated addresses, the drain after a full rewrite, back-to-back frame repairs and slow acknowledgements.

// File: rtl/upset_pkg.sv
package upset_pkg;
  typedef enum logic [2:0] {
    CL_NONE    = 3'd0,
    CL_UNKNOWN = 3'd1,
    CL_EVEN    = 3'd2,
    CL_ODD_OOB = 3'd3,
    CL_ODD_INB = 3'd4,
    CL_SBU     = 3'd5,
    CL_DUP     = 3'd6
  } upset_cls_e;

  localparam int unsigned NUM_CLS = 7;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_FRAME = 2'd1,
    ACT_FULL  = 2'd2
  } repair_act_e;
endpackage

// File: rtl/upset_classify.sv
module upset_classify import upset_pkg::*; #(
  parameter int unsigned EV_W        = 64,
  parameter int unsigned FADDR_W     = 26,
  parameter int unsigned WIDX_W      = 7,
  parameter int unsigned BIDX_W      = 5,
  parameter int unsigned FRAME_WORDS = 101
) (
  input  logic [EV_W-1:0]    ev_i,
  input  logic               dup_i,
  output upset_cls_e         cls_o,
  output repair_act_e        act_o,
  output logic [FADDR_W-1:0] addr_o,
  output logic               addr_nz_o
);
  localparam int unsigned WIDX_LSB = FADDR_W;
  localparam int unsigned BIDX_LSB = WIDX_LSB + WIDX_W;
  localparam int unsigned ECC_POS  = BIDX_LSB + BIDX_W;
  localparam int unsigned CRC_POS  = ECC_POS + 1;
  localparam int unsigned ODD_POS  = CRC_POS + 1;
  // FRAME_WORDS must fit in WIDX_W bits
  localparam logic [WIDX_W-1:0] WIDX_LIM = WIDX_W'(FRAME_WORDS);

  logic [WIDX_W-1:0] widx;
  logic              ecc_f, crc_f, odd_f;
  logic              unused_pad;

  assign addr_o    = ev_i[FADDR_W-1:0];
  assign widx      = ev_i[WIDX_LSB +: WIDX_W];
  assign ecc_f     = ev_i[ECC_POS];
  assign crc_f     = ev_i[CRC_POS];
  assign odd_f     = ev_i[ODD_POS];
  assign addr_nz_o = |addr_o;
  assign unused_pad = ^{ev_i[EV_W-1:ODD_POS+1], ev_i[BIDX_LSB +: BIDX_W]};

  always_comb begin
    cls_o = CL_NONE;
    act_o = ACT_NONE;
    if (!addr_nz_o) begin
      cls_o = CL_NONE;
    end else if (dup_i) begin
      cls_o = CL_DUP;
    end else if (ecc_f) begin
      if (!odd_f) begin
        cls_o = CL_EVEN;
        act_o = ACT_FRAME;
      end else if (widx >= WIDX_LIM) begin
        cls_o = CL_ODD_OOB;
        act_o = ACT_FULL;
      end else if (crc_f) begin
        cls_o = CL_ODD_INB;
        act_o = ACT_FRAME;
      end else begin
        cls_o = CL_SBU;
      end
    end else if (crc_f) begin
      cls_o = CL_UNKNOWN;
      act_o = ACT_FULL;
    end
  end
endmodule

// File: rtl/upset_dup_track.sv
module upset_dup_track #(
  parameter int unsigned FADDR_W = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FADDR_W-1:0] addr_i,
  input  logic               upd_i,
  input  logic               load_i,
  output logic               match_o
);
  logic               valid_q;
  logic [FADDR_W-1:0] addr_q;

  assign match_o = valid_q && (addr_q == addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (upd_i) begin
      if (load_i) begin
        valid_q <= 1'b1;
        addr_q  <= addr_i;
      end else if (!match_o) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/upset_counters.sv
module upset_counters import upset_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     inc_i,
  input  upset_cls_e               cls_i,
  output logic [NUM_CLS*CNT_W-1:0] cnt_o
);
  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cnt_q <= '0;
      else if (inc_i && (cls_i == upset_cls_e'(k))) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[k*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/upset_dispatch.sv
module upset_dispatch import upset_pkg::*; #(
  parameter int unsigned EV_W        = 64,
  parameter int unsigned FADDR_W     = 26,
  parameter int unsigned WIDX_W      = 7,
  parameter int unsigned BIDX_W      = 5,
  parameter int unsigned FRAME_WORDS = 101,
  parameter int unsigned CNT_W       = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     q_nempty_i,
  output logic                     q_pop_o,
  input  logic [EV_W-1:0]          q_data_i,
  output logic                     rep_req_o,
  output logic                     rep_full_o,
  output logic [FADDR_W-1:0]       rep_addr_o,
  input  logic                     rep_ack_i,
  output logic                     cls_valid_o,
  output logic [2:0]               cls_o,
  output logic [NUM_CLS*CNT_W-1:0] cnt_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_WAIT, ST_DRAIN} st_e;

  st_e                st_q;
  logic [EV_W-1:0]    ev_q;
  upset_cls_e         cls_w, cls_q;
  repair_act_e        act_w;
  logic [FADDR_W-1:0] addr_w;
  logic               addr_nz_w, dup_w, eval_w;

  assign eval_w  = (st_q == ST_EVAL);
  assign q_pop_o = q_nempty_i && ((st_q == ST_IDLE) || (st_q == ST_DRAIN));

  upset_classify #(
    .EV_W(EV_W), .FADDR_W(FADDR_W), .WIDX_W(WIDX_W),
    .BIDX_W(BIDX_W), .FRAME_WORDS(FRAME_WORDS)
  ) i_classify (
    .ev_i(ev_q), .dup_i(dup_w), .cls_o(cls_w), .act_o(act_w),
    .addr_o(addr_w), .addr_nz_o(addr_nz_w)
  );

  upset_dup_track #(.FADDR_W(FADDR_W)) i_dup (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_w),
    .upd_i(eval_w && addr_nz_w), .load_i(act_w != ACT_NONE),
    .match_o(dup_w)
  );

  upset_counters #(.CNT_W(CNT_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(eval_w), .cls_i(cls_w), .cnt_o(cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ev_q        <= '0;
      cls_q       <= CL_NONE;
      cls_valid_o <= 1'b0;
      rep_req_o   <= 1'b0;
      rep_full_o  <= 1'b0;
      rep_addr_o  <= '0;
    end else begin
      cls_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (q_nempty_i) begin
          ev_q <= q_data_i;
          st_q <= ST_EVAL;
        end
        ST_EVAL: begin
          cls_q       <= cls_w;
          cls_valid_o <= 1'b1;
          if (act_w != ACT_NONE) begin
            rep_req_o  <= 1'b1;
            rep_full_o <= (act_w == ACT_FULL);
            rep_addr_o <= addr_w;
            st_q       <= ST_WAIT;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_WAIT: if (rep_ack_i) begin
          rep_req_o <= 1'b0;
          st_q      <= rep_full_o ? ST_DRAIN : ST_IDLE;
        end
        ST_DRAIN: if (!q_nempty_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cls_o = cls_q;
endmodule

// File: rtl/upset_dispatch_chk.sv
module upset_dispatch_chk #(
  parameter int unsigned FADDR_W = 26
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               q_nempty_i,
  input logic               q_pop_o,
  input logic               rep_req_o,
  input logic               rep_full_o,
  input logic [FADDR_W-1:0] rep_addr_o,
  input logic               rep_ack_i,
  input logic               cls_valid_o,
  input logic [2:0]         cls_o
);
  // R9
  pop_while_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_req_o |-> !q_pop_o);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_req_o && !rep_ack_i) |=> (rep_req_o && $stable(rep_addr_o) && $stable(rep_full_o)));

  // R8
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop_o |-> q_nempty_i);

  // R12
  cls_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_valid_o |=> !cls_valid_o);

  // R12
  req_with_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rep_req_o) |-> cls_valid_o);

  // R2
  // R4
  full_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rep_req_o) |-> (rep_full_o == ((cls_o == 3'd1) || (cls_o == 3'd3))));

  // R3
  frame_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rep_req_o) && !rep_full_o) |-> (rep_addr_o != '0));

  // R1
  // R5
  // R7
  no_repair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_valid_o && ((cls_o == 3'd0) || (cls_o == 3'd5) || (cls_o == 3'd6))) |-> !rep_req_o);
endmodule

bind upset_dispatch upset_dispatch_chk #(.FADDR_W(FADDR_W)) i_upset_dispatch_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .q_nempty_i(q_nempty_i), .q_pop_o(q_pop_o),
  .rep_req_o(rep_req_o), .rep_full_o(rep_full_o), .rep_addr_o(rep_addr_o),
  .rep_ack_i(rep_ack_i), .cls_valid_o(cls_valid_o), .cls_o(cls_o)
);

// File: tb/test_upset_dispatch.sv
module test_upset_dispatch;
  localparam int unsigned FADDR_W = 4;
  localparam int unsigned WIDX_W  = 3;
  localparam int unsigned BIDX_W  = 2;
  localparam int unsigned FW      = 5;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned NCLS    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_nempty, q_pop, rep_req, rep_full, rep_ack, cls_valid;
  logic [63:0] q_data;
  logic [FADDR_W-1:0] rep_addr;
  logic [2:0] cls;
  logic [NCLS*CNT_W-1:0] cnt;

  always #5 clk = ~clk;

  logic [63:0] qmem [0:255];
  int head = 0;
  int tail = 0;
  assign q_nempty = (head != tail);
  assign q_data   = qmem[head % 256];
  always @(posedge clk) if (q_pop) head <= head + 1;

  upset_dispatch #(
    .EV_W(64), .FADDR_W(FADDR_W), .WIDX_W(WIDX_W), .BIDX_W(BIDX_W),
    .FRAME_WORDS(FW), .CNT_W(CNT_W)
  ) i_upset_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .q_nempty_i(q_nempty), .q_pop_o(q_pop),
    .q_data_i(q_data), .rep_req_o(rep_req), .rep_full_o(rep_full),
    .rep_addr_o(rep_addr), .rep_ack_i(rep_ack), .cls_valid_o(cls_valid),
    .cls_o(cls), .cnt_o(cnt)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // observation and acknowledge logic
  int n_cls = 0, n_req = 0, obs_cls = 0, ack_dly = 1, ack_cnt = 0;
  bit obs_full = 0;
  int obs_addr = 0;
  bit prev_req = 0;
  bit prev_full = 0;
  logic [FADDR_W-1:0] prev_addr = '0;
  initial rep_ack = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rep_req && q_pop) chk(1'b0, "R9 pop during request", 1, 0);
      if (prev_req && !rep_ack)
        chk(rep_req && rep_full == prev_full && rep_addr == prev_addr,
            "R9 request hold", rep_req, 1);
      if (cls_valid) begin n_cls++; obs_cls = int'(cls); end
      if (rep_req && !prev_req) begin
        n_req++; obs_full = rep_full; obs_addr = int'(rep_addr);
      end
      prev_req = rep_req; prev_full = rep_full; prev_addr = rep_addr;
      if (rep_ack) begin
        rep_ack = 1'b0;
      end else if (rep_req) begin
        if (ack_cnt >= ack_dly) begin rep_ack = 1'b1; ack_cnt = 0; end
        else ack_cnt++;
      end
    end
  end

  // reference model
  bit lv = 0;
  int la = 0;
  int tally [NCLS];

  function automatic logic [63:0] mk_ev(int a, int w, int b, bit e, bit c, bit o);
    logic [63:0] v;
    v = '0;
    v[3:0] = 4'(a); v[6:4] = 3'(w); v[8:7] = 2'(b);
    v[9] = e; v[10] = c; v[11] = o;
    v[63:12] = {13{4'(w + 9)}};
    return v;
  endfunction

  task automatic model(input logic [63:0] ev, output int c, output int act);
    int a, w;
    a = int'(ev[3:0]); w = int'(ev[6:4]);
    act = 0;
    if (a == 0) c = 0;
    else if (lv && la == a) c = 6;
    else begin
      lv = 0;
      if (ev[9]) begin
        if (!ev[11]) begin c = 2; act = 1; end
        else if (w >= FW) begin c = 3; act = 2; end
        else if (ev[10]) begin c = 4; act = 1; end
        else c = 5;
      end else if (ev[10]) begin c = 1; act = 2; end
      else c = 0;
      if (act != 0) begin lv = 1; la = a; end
    end
    tally[c]++;
  endtask

  function automatic string tag_of(int c);
    case (c)
      0: return "R1 R6 none";
      1: return "R2 unknown";
      2: return "R3 even";
      3: return "R4 odd out of bounds";
      4: return "R5 odd in bounds";
      5: return "R5 corrected single";
      default: return "R7 duplicate";
    endcase
  endfunction

  task automatic push(input logic [63:0] ev);
    qmem[tail % 256] = ev;
    tail = tail + 1;
  endtask

  task automatic wait_idle();
    int st = 0;
    while (st < 3) begin
      @(negedge clk);
      if (head == tail && !rep_req && !cls_valid) st++;
      else st = 0;
    end
  endtask

  task automatic finish_one(input logic [63:0] ev, input int ec, input int ea);
    string t;
    t = tag_of(ec);
    chk(n_cls == 1, {t, " class strobe count"}, n_cls, 1);
    chk(obs_cls == ec, {t, " class"}, obs_cls, ec);
    chk(n_req == (ea != 0 ? 1 : 0), {t, " request count"}, n_req, ea != 0);
    if (ea != 0 && n_req == 1) begin
      chk(obs_full == (ea == 2), {t, " full flag"}, obs_full, ea == 2);
      chk(obs_addr == int'(ev[3:0]), {t, " address"}, obs_addr, ev[3:0]);
    end
  endtask

  task automatic run_one(input logic [63:0] ev);
    int ec, ea;
    model(ev, ec, ea);
    n_cls = 0; n_req = 0;
    push(ev);
    wait_idle();
    finish_one(ev, ec, ea);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ec, ea;
    logic [63:0] ev;
    for (int k = 0; k < NCLS; k++) tally[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!q_pop && !rep_req && !cls_valid, "R11 reset outputs", {q_pop, rep_req, cls_valid}, 0);
    chk(cnt == '0, "R11 reset counters", cnt, 0);

    // R12 latency
    ev = mk_ev(2, 0, 1, 1, 0, 0);
    model(ev, ec, ea);
    n_cls = 0; n_req = 0;
    push(ev);
    #1 chk(q_pop == 1'b1, "R12 pop on nonempty", q_pop, 1);
    @(negedge clk);
    chk(!cls_valid && !rep_req, "R12 nothing one cycle after pop", cls_valid, 0);
    @(negedge clk);
    chk(cls_valid && rep_req, "R12 strobe and request", {cls_valid, rep_req}, 3);
    wait_idle();
    finish_one(ev, ec, ea);

    // R7 directed duplicates
    run_one(mk_ev(3, 1, 0, 1, 0, 0));
    run_one(mk_ev(3, 2, 1, 1, 1, 0));
    run_one(mk_ev(3, 0, 0, 0, 1, 0));
    run_one(mk_ev(4, 1, 0, 1, 0, 1));
    run_one(mk_ev(3, 1, 0, 1, 0, 0));
    chk(lv && la == 3, "R7 model state", la, 3);

    // sweep with slow acknowledge on some events
    for (int a = 0; a < 16; a++) begin
      for (int f = 0; f < 64; f++) begin
        ack_dly = (f % 4);
        run_one(mk_ev((a + f) % 16, f % 8, f % 4, f[3], f[4], f[5]));
      end
    end

    // R8 drain after full rewrite
    ack_dly = 6;
    ev = mk_ev(5, 0, 0, 0, 1, 0);
    model(ev, ec, ea);
    n_cls = 0; n_req = 0;
    push(ev);
    push(mk_ev(6, 1, 0, 1, 0, 0));
    push(mk_ev(7, 1, 0, 1, 0, 1));
    push(mk_ev(8, 2, 0, 1, 0, 0));
    wait_idle();
    chk(n_cls == 1, "R8 only first event classified", n_cls, 1);
    chk(obs_cls == 1 && obs_full, "R8 full rewrite issued", obs_cls, 1);
    chk(head == tail, "R8 queue drained", tail - head, 0);

    // two frame repairs queued back to back: no drain
    ack_dly = 3;
    n_cls = 0; n_req = 0;
    ev = mk_ev(9, 1, 0, 1, 0, 0);
    model(ev, ec, ea);
    push(ev);
    ev = mk_ev(10, 1, 0, 1, 1, 1);
    model(ev, ec, ea);
    push(ev);
    wait_idle();
    chk(n_cls == 2 && n_req == 2, "R9 R3 queued frame repairs both served", n_cls, 2);
    chk(obs_cls == 4 && !obs_full && obs_addr == 10, "R5 second event in bounds", obs_cls, 4);

    // R10 counters
    for (int k = 0; k < NCLS; k++)
      chk(int'(cnt[k*CNT_W +: CNT_W]) == tally[k], "R10 class counter",
          cnt[k*CNT_W +: CNT_W], tally[k]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule